// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address of every beat of an SDRAM burst, one beat per clock, for use inside a memory controller or a behavioural memory model. A start strobe captures an 8-bit starting column, a 3-bit burst length code and a burst type bit. From the next cycle on, the block presents the current column with a beat-valid flag. It steps to the following beat on each cycle where the advance input is high.

Two orderings are supported inside the burst-aligned block of the start column. In sequential order the low bits count up and wrap. In interleave order the low bits are the start low bits XOR the beat number. The upper column bits never move for lengths 1, 2, 4 and 8. A full-page burst is accepted only in sequential order. It walks through all 256 columns, wraps from 255 to 0 and runs until the abort input ends it. A length code or type combination that is not supported raises an error pulse and starts no burst.

Top module: `sdram_burst_colseq`

## Requirements
- R1: While reset is active and in the first cycle after it, valid_o, last_o and err_o are low.
- R2: A start with a legal combination makes valid_o high in the next cycle, with col_o equal to the captured start column (beat 0). This holds even when the start arrives during a burst: the start has priority over advance and abort, and the new burst replaces the old one.
- R3: With valid_o high, a cycle with adv_i high moves to the next beat in the following cycle. A cycle with adv_i low, start_i low and abort_i low keeps col_o, last_o and valid_o unchanged.
- R4: Sequential order (btype_i = 0), length BL in {1,2,4,8}: beat n has low log2(BL) column bits = (start low bits + n) mod BL, and the upper bits equal the start column's upper bits.
- R5: Interleave order (btype_i = 1), length BL in {1,2,4,8}: beat n has low log2(BL) column bits = start low bits XOR n, and the upper bits equal the start column's upper bits.
- R6: The length code bl_code_i is decoded as 3'b000 = 1, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page.
- R7: last_o is high exactly while beat BL-1 is presented. When adv_i is high on that beat, valid_o is low in the next cycle.
- R8: A full-page burst (code 3'b111, sequential) presents start+n mod 256 on beat n, wrapping from 255 to 0. It never raises last_o.
- R9: abort_i high while start_i is low ends any burst: valid_o is low in the next cycle.
- R10: Codes 3'b100, 3'b101 and 3'b110 with either type are illegal, and so is code 3'b111 with interleave. A start with an illegal combination makes err_o high for exactly the next cycle, starts no burst and ends any burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures column, code and type |
| start_col_i | input | 8 | Starting column |
| bl_code_i | input | 3 | Burst length code |
| btype_i | input | 1 | Burst type: 0 sequential, 1 interleave |
| adv_i | input | 1 | Advance to the next beat |
| abort_i | input | 1 | Ends the current burst |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Illegal combination at the last start |

## Verification
Every output comes from a register, so each result is due one cycle after the edge that causes it. The first beat and the error pulse appear in the cycle after the start. A new beat, or the end of the burst, appears in the cycle after an edge with adv_i or abort_i high. The bench drives inputs just after a rising edge and samples on the falling edge. The scoreboard compares the front expected beat on every falling edge where valid_o is high, and it pops that beat only when adv_i is high for the coming edge, so held beats are compared again on each cycle. The monitor skips cycles where a start or an abort is pending, because the displayed beat belongs to the burst being replaced. The error pulse and the idle state after a burst are checked directly on the falling edge one and two cycles after the cause.

// File: rtl/sdram_colseq_pkg.sv
package sdram_colseq_pkg;
  localparam int unsigned CODE_W = 3;

  localparam logic [CODE_W-1:0] BLC_1    = 3'b000;
  localparam logic [CODE_W-1:0] BLC_2    = 3'b001;
  localparam logic [CODE_W-1:0] BLC_4    = 3'b010;
  localparam logic [CODE_W-1:0] BLC_8    = 3'b011;
  localparam logic [CODE_W-1:0] BLC_PAGE = 3'b111;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

  typedef struct packed {
    logic legal;
    logic page;
  } len_info_t;
endpackage

// File: rtl/colseq_len_decode.sv
module colseq_len_decode
  import sdram_colseq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  order_e            order_i,
  output logic [COL_W-1:0]  mask_o,
  output len_info_t         info_o
);
  always_comb begin
    mask_o       = '0;
    info_o.legal = 1'b0;
    info_o.page  = 1'b0;
    unique case (code_i)
      BLC_1, BLC_2, BLC_4, BLC_8: begin
        mask_o       = (COL_W'(1) << code_i[1:0]) - COL_W'(1);
        info_o.legal = 1'b1;
      end
      BLC_PAGE: begin
        mask_o       = '1;
        info_o.page  = 1'b1;
        info_o.legal = (order_i == ORD_SEQ);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/colseq_beat_ctr.sv
module colseq_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic             step_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  output logic [COL_W-1:0] beat_o,
  output logic             active_o,
  output logic             last_o
);
  logic [COL_W-1:0] beat_q, mask_q;
  logic             active_q, page_q;

  // page bursts have no terminal beat
  assign last_o   = active_q && !page_q && (beat_q == mask_q);
  assign beat_o   = beat_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      mask_q   <= '0;
      page_q   <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      mask_q   <= mask_i;
      page_q   <= page_i;
    end else if (kill_i) begin
      active_q <= 1'b0;
    end else if (active_q && step_i) begin
      if (last_o) active_q <= 1'b0;
      else        beat_q   <= beat_q + COL_W'(1);
    end
  end
endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen
  import sdram_colseq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + beat_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic moved;
    assign moved    = (order_i == ORD_ILV) ? (base_i[i] ^ beat_i[i]) : sum[i];
    assign col_o[i] = mask_i[i] ? moved : base_i[i];
  end
endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
  import sdram_colseq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              btype_i,
  input  logic              adv_i,
  input  logic              abort_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              err_o
);
  logic [COL_W-1:0] dec_mask, run_mask, beat, base_q;
  len_info_t        dec_info;
  order_e           order_q;
  logic             load, kill, err_q;

  colseq_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (bl_code_i),
    .order_i(order_e'(btype_i)),
    .mask_o (dec_mask),
    .info_o (dec_info)
  );

  assign load = start_i && dec_info.legal;
  assign kill = (start_i && !dec_info.legal) || abort_i;

  colseq_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .kill_i  (kill),
    .step_i  (adv_i),
    .mask_i  (dec_mask),
    .page_i  (dec_info.page),
    .beat_o  (beat),
    .active_o(valid_o),
    .last_o  (last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      order_q  <= ORD_SEQ;
      run_mask <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= start_i && !dec_info.legal;
      if (load) begin
        base_q   <= start_col_i;
        order_q  <= order_e'(btype_i);
        run_mask <= dec_mask;
      end
    end
  end

  colseq_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_q),
    .beat_i (beat),
    .mask_i (run_mask),
    .order_i(order_q),
    .col_o  (col_o)
  );

  assign err_o = err_q;
endmodule

// File: rtl/sdram_colseq_chk.sv
module sdram_colseq_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             btype_i,
  input logic             adv_i,
  input logic             abort_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o
);
  logic ok_combo, page_run_q;
  assign ok_combo = (bl_code_i[2] == 1'b0) || (bl_code_i == 3'b111 && !btype_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_run_q <= 1'b0;
    else if (start_i) page_run_q <= ok_combo && (bl_code_i == 3'b111);
  end

  assert_first_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ok_combo |=> valid_o && col_o == $past(start_col_i));

  assert_hold_beat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !adv_i && !start_i && !abort_i |=> valid_o && $stable(col_o) && $stable(last_o));

  assert_last_in_burst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  assert_last_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && adv_i && !start_i |=> !valid_o);

  assert_page_no_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && page_run_q |-> !last_o);

  assert_abort_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && !start_i |=> !valid_o);

  assert_illegal_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !ok_combo |=> err_o && !valid_o);

  assert_err_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> !err_o);
endmodule

bind sdram_burst_colseq sdram_colseq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_sdram_burst_colseq.sv
`timescale 1ns/1ps
module tb_sdram_burst_colseq;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       start_i = 1'b0, btype_i = 1'b0, adv_i = 1'b0, abort_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic [7:0] col_o;
  logic       valid_o, last_o, err_o;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R4";
  logic [8:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  sdram_burst_colseq dut (.*);

  function automatic logic [8:0] exp_beat(logic [7:0] s, logic [2:0] code, logic ilv, int n);
    int len = (code == 3'b111) ? 256 : (1 << code);
    logic [7:0] m   = 8'(len - 1);
    logic [7:0] low = ilv ? ((s ^ 8'(n)) & m) : (8'(s + 8'(n)) & m);
    logic       lst = (code != 3'b111) && (n == len - 1);
    return {lst, (s & ~m) | low};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !start_i && !abort_i && valid_o) begin
      if (exp_q.size() == 0) begin
        check({cur_req, " R7 unexpected beat"}, {23'd0, last_o, col_o}, 32'h1ff);
      end else begin
        check({cur_req, " R3 R7 beat"}, {23'd0, last_o, col_o}, {23'd0, exp_q[0]});
        if (adv_i) void'(exp_q.pop_front());
      end
    end
  end

  // end_mode: 0 run to the end, 1 abort after k beats, 2 leave running after k beats
  task automatic burst(string req, logic [7:0] s, logic [2:0] code, logic ilv,
                       bit gaps, int end_mode, int k);
    int len = (code == 3'b111) ? 256 : (1 << code);
    int nb  = (end_mode == 0) ? len : ((end_mode == 2) ? k + 1 : k);
    int nr  = (end_mode == 0) ? len : k;
    exp_q.delete();
    for (int n = 0; n < nb; n++) exp_q.push_back(exp_beat(s, code, ilv, n));
    cur_req = req;
    start_i = 1'b1; start_col_i = s; bl_code_i = code; btype_i = ilv; adv_i = 1'b0;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    for (int i = 0; i < nr; i++) begin
      if (gaps && (i % 2 == 1)) begin
        adv_i = 1'b0; @(posedge clk_i); #1;
      end
      adv_i = 1'b1; @(posedge clk_i); #1;
    end
    adv_i = 1'b0;
    if (end_mode == 1) begin
      abort_i = 1'b1; @(posedge clk_i); #1;
      abort_i = 1'b0; exp_q.delete();
    end
    if (end_mode != 2) begin
      @(negedge clk_i);
      check({req, " R7 R9 idle after burst"}, {31'd0, valid_o}, 32'd0);
      check({req, " all beats seen"}, exp_q.size(), 32'd0);
      @(posedge clk_i); #1;
    end
  endtask

  task automatic illegal(logic [2:0] code, logic ilv);
    exp_q.delete();
    start_i = 1'b1; bl_code_i = code; btype_i = ilv; start_col_i = 8'h2c;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    @(negedge clk_i);
    check("R10 err pulse", {30'd0, err_o, valid_o}, 32'b10);
    @(posedge clk_i); #1;
    @(negedge clk_i);
    check("R10 err one cycle", {30'd0, err_o, valid_o}, 32'b00);
    @(posedge clk_i); #1;
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 reset state", {29'd0, valid_o, last_o, err_o}, 32'd0);
    #9 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    check("R1 after reset", {29'd0, valid_o, last_o, err_o}, 32'd0);
    @(posedge clk_i); #1;

    burst("R4 R6 seq8",     8'h35, 3'b011, 1'b0, 1'b0, 0, 0);
    burst("R4 R6 seq4",     8'ha2, 3'b010, 1'b0, 1'b1, 0, 0);
    burst("R4 R6 seq2",     8'hff, 3'b001, 1'b0, 1'b1, 0, 0);
    burst("R4 R6 seq1",     8'h40, 3'b000, 1'b0, 1'b0, 0, 0);
    burst("R5 R6 ilv8",     8'h5d, 3'b011, 1'b1, 1'b1, 0, 0);
    burst("R5 R6 ilv4",     8'h07, 3'b010, 1'b1, 1'b0, 0, 0);
    burst("R5 R6 ilv2",     8'h13, 3'b001, 1'b1, 1'b1, 0, 0);
    burst("R5 R6 ilv1",     8'h9e, 3'b000, 1'b1, 1'b0, 0, 0);
    burst("R8 R9 fullpage", 8'hfb, 3'b111, 1'b0, 1'b0, 1, 260);
    burst("R9 abort seq8",  8'h11, 3'b011, 1'b0, 1'b1, 1, 3);

    // R11-style restart: start during a running burst (R2 priority)
    burst("R2 restart old", 8'hc4, 3'b011, 1'b0, 1'b0, 2, 2);
    start_col_i = 8'h66; bl_code_i = 3'b010; btype_i = 1'b1;
    abort_i = 1'b1; adv_i = 1'b1;
    exp_q.delete();
    for (int n = 0; n < 4; n++) exp_q.push_back(exp_beat(8'h66, 3'b010, 1'b1, n));
    cur_req = "R2 restart new";
    start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0; abort_i = 1'b0; adv_i = 1'b0;
    @(negedge clk_i);
    check("R2 restart first beat", {23'd0, valid_o, col_o}, {23'd0, 1'b1, 8'h66});
    @(posedge clk_i); #1;
    for (int i = 0; i < 4; i++) begin
      adv_i = 1'b1; @(posedge clk_i); #1;
    end
    adv_i = 1'b0;
    @(negedge clk_i);
    check("R2 R7 restart done", {31'd0, valid_o}, 32'd0);
    @(posedge clk_i); #1;

    illegal(3'b111, 1'b1);
    illegal(3'b100, 1'b0);
    illegal(3'b101, 1'b1);
    illegal(3'b110, 1'b0);

    // illegal start ends a running burst
    burst("R10 victim", 8'h80, 3'b011, 1'b0, 1'b0, 2, 1);
    illegal(3'b110, 1'b1);

    burst("R4 after error", 8'h3a, 3'b011, 1'b0, 1'b1, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule